// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block keeps the time of day as four packed BCD registers: seconds, minutes, hours and day of the week. A one-second tick advances it, and an active-high stop control can halt it. Seconds and minutes wrap at 59 and carry into the next field. The hours register holds its own format bit, so software picks a 24-hour or a 12-hour count by writing that bit along with the hour value. In 12-hour mode the register also holds an afternoon flag. The day of the week cycles through seven values and advances at midnight.

A host can load any field at any time through a simple write port. The field select follows the register order seconds, minutes, hours, day. A write replaces the field on the next clock edge. It takes the place of that field's own increment in the same cycle. Carries that the old values would produce still reach the other fields.

Top module: `tod_counter`

## Requirements
- R1: Seconds count in BCD from 00 to 59, one step per enabled tick (`tick_i`=1 and `osc_stop_i`=0), visible on the cycle after that tick. After 59 the value becomes 00 and a carry goes to minutes.
- R2: Minutes count in BCD from 00 to 59. They advance only when seconds wrap from 59, and they wrap from 59 to 00, carrying into hours.
- R3: While `osc_stop_i` is 1, ticks have no effect and no field changes.
- R4: With hours bit 6 = 0 (24-hour), bits 5:4 hold the tens digit (0 to 2) and bits 3:0 the units. The hour sequence 00..23 wraps from 23 to 00, and that wrap advances the day.
- R5: With hours bit 6 = 1 (12-hour), bit 5 is the PM flag (1 = PM), bit 4 is the tens digit and bits 3:0 the units. Hour 11 goes to 12 and toggles bit 5. Hour 12 goes to 01 and keeps bit 5. Bit 6 is preserved.
- R6: In 12-hour mode the day advances on the step from 11 PM to 12 AM, and not on the step from 11 AM to 12 PM.
- R7: The day field counts 1 to 7 and wraps from 7 to 1.
- R8: A write (`wr_en_i`=1) loads `wr_data_i` into the field picked by `wr_sel_i` (0 seconds, 1 minutes, 2 hours, 3 day), visible on the next cycle. Unused bits read 0: bit 7 of seconds, minutes and hours, and bits 7:3 of day.
- R9: In a cycle with both a write and an enabled tick, the written field takes the written value and skips its own increment. Other fields still advance, using carries computed from the values held before the write.
- R10: After reset the fields read seconds 00, minutes 00, hours 00 in 24-hour mode, and day 1.
- R11: With no enabled tick and no write, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| osc_stop_i | input | 1 | 1 halts counting |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Field select: 0 sec, 1 min, 2 hour, 3 day |
| wr_data_i | input | 8 | Write data, packed BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and PM/tens bit |
| day_o | output | 8 | Day of week, 1 to 7 |

## Verification
A wrong digit or a broken carry shows on the outputs one cycle after the enabled tick that should have produced the correct value. The reference model is compared with the design after every clock, so the fault is reported at that step. Some faults only appear at a rollover: the PM flip, the midnight day carry, or the 7-to-1 day wrap. For each of these, the bench loads the field values just before the boundary and then steps across it. A long run of ticks also walks through the ordinary 9-to-10 digit carries.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SEC_W  = 7;
    localparam int HOUR_W = 7;
    localparam int DAY_W  = 3;
    localparam int BUS_W  = 8;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } tod_field_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [SEC_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [DAY_W-1:0]  day;
    } tod_state_t;
endpackage

// File: rtl/tod_bcd_wrap.sv
// Two-digit BCD step with a configurable top value; wraps to 00.
module tod_bcd_wrap #(
    parameter int TOP_TENS = 5,
    parameter int TOP_ONES = 9,
    parameter int VAL_W    = 7
) (
    input  logic [VAL_W-1:0] val_i,
    input  logic             step_i,
    output logic [VAL_W-1:0] next_o,
    output logic             carry_o
);
    localparam int TENS_W = VAL_W - 4;

    logic [TENS_W-1:0] tens;
    logic [3:0]        ones;
    logic              at_top;

    assign tens   = val_i[VAL_W-1:4];
    assign ones   = val_i[3:0];
    assign at_top = (tens == TENS_W'(TOP_TENS)) && (ones == 4'(TOP_ONES));

    always_comb begin
        next_o = val_i;
        if (step_i) begin
            if (at_top) begin
                next_o = '0;
            end else if (ones >= 4'd9) begin
                next_o = {tens + TENS_W'(1), 4'd0};
            end else begin
                next_o = {tens, ones + 4'd1};
            end
        end
    end

    assign carry_o = step_i && at_top;
endmodule

// File: rtl/tod_hour_step.sv
// Hour advance for both encodings; bit 6 of the register selects 12-hour mode.
module tod_hour_step #(
    parameter int HOUR_W = 7
) (
    input  logic [HOUR_W-1:0] hour_i,
    input  logic              step_i,
    output logic [HOUR_W-1:0] next_o,
    output logic              day_carry_o
);
    logic       mode12;
    logic       pm;
    logic [1:0] tens24;
    logic       tens12;
    logic [3:0] ones;

    assign mode12 = hour_i[6];
    assign pm     = hour_i[5];
    assign tens24 = hour_i[5:4];
    assign tens12 = hour_i[4];
    assign ones   = hour_i[3:0];

    always_comb begin
        next_o      = hour_i;
        day_carry_o = 1'b0;
        if (step_i) begin
            if (mode12) begin
                if (tens12 && ones == 4'd1) begin
                    next_o      = {1'b1, ~pm, 1'b1, 4'd2};
                    day_carry_o = pm;
                end else if (tens12 && ones == 4'd2) begin
                    next_o = {1'b1, pm, 1'b0, 4'd1};
                end else if (ones >= 4'd9) begin
                    next_o = {1'b1, pm, 1'b1, 4'd0};
                end else begin
                    next_o = {1'b1, pm, tens12, ones + 4'd1};
                end
            end else begin
                if (tens24 == 2'd2 && ones == 4'd3) begin
                    next_o      = '0;
                    day_carry_o = 1'b1;
                end else if (ones >= 4'd9) begin
                    next_o = {1'b0, tens24 + 2'd1, 4'd0};
                end else begin
                    next_o = {1'b0, tens24, ones + 4'd1};
                end
            end
        end
    end
endmodule

// File: rtl/tod_day_step.sv
// Day-of-week step, 1 .. DAYS then back to 1.
module tod_day_step #(
    parameter int DAYS  = 7,
    parameter int DAY_W = 3
) (
    input  logic [DAY_W-1:0] day_i,
    input  logic             step_i,
    output logic [DAY_W-1:0] next_o
);
    always_comb begin
        next_o = day_i;
        if (step_i) begin
            if (day_i >= DAY_W'(DAYS)) begin
                next_o = DAY_W'(1);
            end else begin
                next_o = day_i + DAY_W'(1);
            end
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int DAYS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             osc_stop_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [BUS_W-1:0] wr_data_i,
    output logic [BUS_W-1:0] sec_o,
    output logic [BUS_W-1:0] min_o,
    output logic [BUS_W-1:0] hour_o,
    output logic [BUS_W-1:0] day_o
);
    localparam int LANES = 2;

    tod_state_t cur_q, nxt_d;

    logic             adv;
    logic [SEC_W-1:0] lane_val   [LANES];
    logic [SEC_W-1:0] lane_next  [LANES];
    logic             lane_step  [LANES];
    logic             lane_carry [LANES];
    logic [HOUR_W-1:0] hour_next;
    logic              hour_carry;
    logic [DAY_W-1:0]  day_next;

    assign adv         = tick_i && !osc_stop_i;
    assign lane_val[0] = cur_q.sec;
    assign lane_val[1] = cur_q.min;

    // seconds (lane 0) and minutes (lane 1) share one BCD 00..59 stepper
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lane_step[g] = adv;
        end else begin : g_chain
            assign lane_step[g] = lane_carry[g-1];
        end
        tod_bcd_wrap #(
            .TOP_TENS (5),
            .TOP_ONES (9),
            .VAL_W    (SEC_W)
        ) u_wrap (
            .val_i   (lane_val[g]),
            .step_i  (lane_step[g]),
            .next_o  (lane_next[g]),
            .carry_o (lane_carry[g])
        );
    end

    tod_hour_step #(
        .HOUR_W (HOUR_W)
    ) u_hour (
        .hour_i      (cur_q.hour),
        .step_i      (lane_carry[LANES-1]),
        .next_o      (hour_next),
        .day_carry_o (hour_carry)
    );

    tod_day_step #(
        .DAYS  (DAYS),
        .DAY_W (DAY_W)
    ) u_day (
        .day_i  (cur_q.day),
        .step_i (hour_carry),
        .next_o (day_next)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sec  = lane_next[0];
        nxt_d.min  = lane_next[1];
        nxt_d.hour = hour_next;
        nxt_d.day  = day_next;
        if (wr_en_i) begin
            unique case (tod_field_e'(wr_sel_i))
                FLD_SEC:  nxt_d.sec  = wr_data_i[SEC_W-1:0];
                FLD_MIN:  nxt_d.min  = wr_data_i[SEC_W-1:0];
                FLD_HOUR: nxt_d.hour = wr_data_i[HOUR_W-1:0];
                FLD_DAY:  nxt_d.day  = wr_data_i[DAY_W-1:0];
                default:  nxt_d      = nxt_d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.sec  <= '0;
            cur_q.min  <= '0;
            cur_q.hour <= '0;
            cur_q.day  <= DAY_W'(1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sec_o  = {{(BUS_W-SEC_W){1'b0}}, cur_q.sec};
    assign min_o  = {{(BUS_W-SEC_W){1'b0}}, cur_q.min};
    assign hour_o = {{(BUS_W-HOUR_W){1'b0}}, cur_q.hour};
    assign day_o  = {{(BUS_W-DAY_W){1'b0}}, cur_q.day};
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       osc_stop_i,
    input logic       wr_en_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] day_o
);
    logic adv_nw;
    assign adv_nw = tick_i && !osc_stop_i && !wr_en_i;

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(day_o)));

    assert_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(day_o)));

    assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_nw && sec_o == 8'h59) |=> (sec_o == 8'h00));

    assert_min_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_nw && sec_o == 8'h59 && min_o == 8'h59) |=> (min_o == 8'h00));

    assert_midnight24_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_nw && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23)
        |=> (hour_o == 8'h00 && day_o != $past(day_o)));

    assert_pm_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_nw && sec_o == 8'h59 && min_o == 8'h59 && hour_o[6] && hour_o[4:0] == 5'h11)
        |=> (hour_o[5] != $past(hour_o[5]) && hour_o[4:0] == 5'h12));
endmodule

bind tod_counter tod_counter_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .osc_stop_i (osc_stop_i),
    .wr_en_i    (wr_en_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .day_o      (day_o)
);

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       osc_stop_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = 2'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, day_o;

    int checks = 0;
    int errors = 0;
    string phase = "R10";
    bit done = 1'b0;

    // reference state as plain integers
    int m_sec, m_min, m_hour, m_day;
    bit m_mode12, m_pm;

    always #5 clk = ~clk;

    tod_counter dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_stop_i(osc_stop_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o)
    );

    function automatic int dec(input int b);
        return ((b >> 4) & 4'hF) * 10 + (b & 4'hF);
    endfunction

    function automatic int bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int exp_hour();
        if (m_mode12) return 8'h40 | (m_pm ? 8'h20 : 0) | bcd(m_hour);
        return bcd(m_hour);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mode12 = 0; m_pm = 0;
        end else begin
            int ns, nm, nh, nd;
            bit npm, c_s, c_m, c_h;
            ns = m_sec; nm = m_min; nh = m_hour; nd = m_day; npm = m_pm;
            c_s = 0; c_m = 0; c_h = 0;
            if (tick_i && !osc_stop_i) begin
                c_s = (m_sec == 59);
                ns = (m_sec + 1) % 60;
                if (c_s) begin
                    c_m = (m_min == 59);
                    nm = (m_min + 1) % 60;
                end
                if (c_m) begin
                    if (m_mode12) begin
                        if (m_hour == 11) begin nh = 12; npm = !m_pm; c_h = m_pm; end
                        else if (m_hour == 12) nh = 1;
                        else nh = m_hour + 1;
                    end else begin
                        c_h = (m_hour == 23);
                        nh = (m_hour + 1) % 24;
                    end
                end
                if (c_h) nd = (m_day == 7) ? 1 : m_day + 1;
            end
            if (wr_en_i) begin
                case (wr_sel_i)
                    2'd0: ns = dec(wr_data_i & 8'h7F);
                    2'd1: nm = dec(wr_data_i & 8'h7F);
                    2'd2: begin
                        if (wr_data_i[6]) begin
                            m_mode12 = 1; npm = wr_data_i[5]; nh = dec(wr_data_i & 8'h1F);
                        end else begin
                            m_mode12 = 0; npm = 0; nh = dec(wr_data_i & 8'h3F);
                        end
                    end
                    default: nd = wr_data_i & 8'h07;
                endcase
            end
            m_sec = ns; m_min = nm; m_hour = nh; m_day = nd; m_pm = npm;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("sec", sec_o, bcd(m_sec));
        chk("min", min_o, bcd(m_min));
        chk("hour", hour_o, exp_hour());
        chk("day", day_o, m_day);
    endtask

    // compare at the falling edge, then drive the inputs for the next rising edge
    task automatic cyc(input bit t, input bit stop, input bit we, input int sel, input int data);
        @(negedge clk);
        compare_all();
        tick_i = t; osc_stop_i = stop; wr_en_i = we;
        wr_sel_i = 2'(sel); wr_data_i = 8'(data);
    endtask

    task automatic load(input int s, input int m, input int h, input int d);
        cyc(0, 0, 1, 0, s);
        cyc(0, 0, 1, 1, m);
        cyc(0, 0, 1, 2, h);
        cyc(0, 0, 1, 3, d);
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R10";
        @(negedge clk);
        chk("sec", sec_o, 8'h00); chk("min", min_o, 8'h00);
        chk("hour", hour_o, 8'h00); chk("day", day_o, 8'h01);

        phase = "R11";
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0);

        phase = "R1";
        load(8'h55, 8'h10, 8'h05, 2);
        ticks(8);

        phase = "R2";
        load(8'h58, 8'h59, 8'h09, 3);
        ticks(4);

        phase = "R8";
        load(8'hD7, 8'hA4, 8'h92, 8'hFD);

        phase = "R3";
        load(8'h59, 8'h59, 8'h23, 4);
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        phase = "R4";
        ticks(3);

        phase = "R7";
        load(8'h59, 8'h59, 8'h23, 7);
        ticks(2);

        phase = "R5";
        load(8'h59, 8'h59, 8'h51, 2);
        ticks(2);
        load(8'h59, 8'h59, 8'h72, 2);
        ticks(2);
        load(8'h59, 8'h59, 8'h49, 2);
        ticks(2);

        phase = "R6";
        load(8'h59, 8'h59, 8'h71, 5);
        ticks(2);

        phase = "R9";
        load(8'h59, 8'h30, 8'h10, 1);
        cyc(1, 0, 1, 0, 8'h20);
        cyc(0, 0, 0, 0, 0);
        load(8'h59, 8'h59, 8'h14, 6);
        cyc(1, 0, 1, 1, 8'h07);
        cyc(0, 0, 0, 0, 0);

        phase = "R4";
        load(8'h00, 8'h00, 8'h22, 3);
        ticks(7300);

        phase = "R5";
        load(8'h00, 8'h00, 8'h50, 3);
        ticks(7300);

        phase = "R11";
        for (int i = 0; i < 4; i++) begin
            cyc(1, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
        end
        cyc(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule